// File: doc/BRIEF.md
# Interval-Based Source Throttling Controller

This block regulates how fast each of N cores may issue memory requests, so that no core is slowed down far more than the others. Decisions are made at the cores, not at the shared memory resources. An external monitor supplies three inputs: a weighted-able slowdown estimate for each core, a matrix of interference counts between core pairs, and a pulse that closes each fixed measurement interval. On that pulse the controller forms a weighted slowdown for every core and picks a victim. It then looks up, in the victim's row of the interference matrix, the core that hurt the victim most. If the fairness goal set by software is missed, that interferer moves one step toward heavier throttling and the victim moves one step toward lighter throttling.

Each core's throttle state is a level on an eight-step ladder. Level 0 is unthrottled. Every step doubles the gap between request issues and halves the number of requests the core may have in flight, down to a floor of one. Two policies are selectable. The ratio policy compares the largest and smallest weighted slowdowns against a single target ratio. The per-core policy compares each core's weighted slowdown against that core's own target.

Top module: `throttle_ctrl`

## Requirements
- R1: While reset is low, every throttle level is 0, every issue period is 1 and every in-flight limit is MSHR_MAX (16).
- R2: Throttle levels change only at a rising clock edge on which `interval_end` is high. On all other edges they hold, whatever the other inputs do.
- R3: A core's weighted slowdown is its slowdown estimate (unsigned, 8 fraction bits) times its weight (unsigned, 4 fraction bits, so 16 means 1.0).
- R4: When `mode` is 0, action is taken only when max_ws × 256 > `unfair_target` × min_ws, with the target given in 8 fraction bits. A ratio exactly equal to the target causes no action.
- R5: When `mode` is 0, the victim is the core with the largest weighted slowdown. On a tie, the lowest index wins.
- R6: The interferer is the core `a` with the largest count in the victim's row, where the count caused by core `a` to core `v` sits at bits [(v*N+a)*CW +: CW] of `interference`. On a tie, the lowest index wins.
- R7: When action is taken, the interferer's level rises by one, saturating at 7. The victim's level falls by one, saturating at 0. All other levels are unchanged.
- R8: If the interferer and the victim are the same core, no level changes.
- R9: When `mode` is 1, a core is in violation when its weighted slowdown exceeds its own target (slice i of `core_target`, 8 fraction bits) scaled by 16. Action is taken if any core violates. The victim is the violator with the largest weighted slowdown, with the lowest index winning a tie.
- R10: For each core, `issue_period` = 2^level and `mshr_limit` = max(1, MSHR_MAX >> level).
- R11: `mode` 0 selects the ratio policy and 1 selects the per-core policy. The same inputs can act under one mode and hold under the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_end | input | 1 | Closes the current interval; decision taken at this edge |
| mode | input | 1 | 0 ratio policy, 1 per-core target policy |
| unfair_target | input | SW | Target max/min ratio, 8 fraction bits |
| core_target | input | N*SW | Per-core slowdown targets, 8 fraction bits |
| slowdown | input | N*SW | Per-core slowdown estimates, 8 fraction bits |
| weight | input | N*WW | Per-core weights, 4 fraction bits |
| interference | input | N*N*CW | Pairwise interference counts, row = victim |
| throttle_lvl | output | N*LW | Per-core throttle level |
| issue_period | output | N*2^LW | Cycles between request issues per core |
| mshr_limit | output | N*MW | Allowed outstanding requests per core |

## Verification
A single update edge both raises the interferer's level and lowers the victim's level, and either move may hit the end of the ladder while the other still moves. The bench drives the same victim and interferer pair over many intervals. The victim then sits at level 0 while the interferer climbs, and after five steps the interferer reaches level 7 and stays there. At each update edge the bench judges all three outputs of all cores against levels it tracks from the requirements. A step where the victim and the interferer are the same core is checked in the same way, and must leave every level unchanged.

// File: rtl/throttle_ctrl.sv
module throttle_ctrl #(
  parameter int N        = 4,
  parameter int SW       = 16,
  parameter int SFRAC    = 8,
  parameter int WW       = 8,
  parameter int WFRAC    = 4,
  parameter int CW       = 16,
  parameter int LW       = 3,
  parameter int MSHR_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                interval_end,
  input  logic                mode,
  input  logic [SW-1:0]       unfair_target,
  input  logic [N*SW-1:0]     core_target,
  input  logic [N*SW-1:0]     slowdown,
  input  logic [N*WW-1:0]     weight,
  input  logic [N*N*CW-1:0]   interference,
  output logic [N*LW-1:0]     throttle_lvl,
  output logic [N*(1<<LW)-1:0] issue_period,
  output logic [N*$clog2(MSHR_MAX+1)-1:0] mshr_limit
);
  localparam int NLVL = 1 << LW;
  localparam int PRW  = NLVL;
  localparam int MW   = $clog2(MSHR_MAX + 1);
  localparam int XW   = SW + WW;
  localparam int UW   = XW + SW;
  localparam int IXW  = (N > 1) ? $clog2(N) : 1;
  localparam logic [LW-1:0] LTOP = LW'(NLVL - 1);

  logic [XW-1:0]  ws [N];
  logic [N-1:0]   over_tgt;
  logic [LW-1:0]  lvl [N];
  logic [IXW-1:0] max_idx, min_idx, viol_idx, victim, agg_idx;
  logic           viol_any, ratio_hit, trigger, do_adj;
  logic [CW-1:0]  best_cnt;

  for (genvar i = 0; i < N; i++) begin : g_core
    logic [MW-1:0] m_raw;
    assign ws[i] = XW'(slowdown[i*SW +: SW]) * XW'(weight[i*WW +: WW]);
    assign over_tgt[i] = ws[i] > XW'({core_target[i*SW +: SW], {WFRAC{1'b0}}});
    assign throttle_lvl[i*LW +: LW] = lvl[i];
    assign issue_period[i*PRW +: PRW] = PRW'(1) << lvl[i];
    assign m_raw = MW'(MSHR_MAX >> lvl[i]);
    assign mshr_limit[i*MW +: MW] = (m_raw == '0) ? MW'(1) : m_raw;
  end

  always_comb begin
    max_idx  = '0;
    min_idx  = '0;
    viol_idx = '0;
    viol_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ws[i] > ws[max_idx]) max_idx = IXW'(i);
      if (ws[i] < ws[min_idx]) min_idx = IXW'(i);
      if (over_tgt[i] && (!viol_any || ws[i] > ws[viol_idx])) begin
        viol_idx = IXW'(i);
        viol_any = 1'b1;
      end
    end
  end

  assign ratio_hit = (UW'(ws[max_idx]) << SFRAC) > (UW'(unfair_target) * UW'(ws[min_idx]));
  assign victim    = mode ? viol_idx : max_idx;
  assign trigger   = mode ? viol_any : ratio_hit;

  always_comb begin
    agg_idx  = '0;
    best_cnt = interference[(int'(victim) * N) * CW +: CW];
    for (int a = 1; a < N; a++) begin
      if (interference[(int'(victim) * N + a) * CW +: CW] > best_cnt) begin
        best_cnt = interference[(int'(victim) * N + a) * CW +: CW];
        agg_idx  = IXW'(a);
      end
    end
  end

  assign do_adj = interval_end && trigger && (agg_idx != victim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) lvl[i] <= '0;
    end else if (do_adj) begin
      for (int i = 0; i < N; i++) begin
        if (IXW'(i) == agg_idx && lvl[i] != LTOP) lvl[i] <= lvl[i] + 1'b1;
        if (IXW'(i) == victim && lvl[i] != '0)    lvl[i] <= lvl[i] - 1'b1;
      end
    end
  end

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> $stable(throttle_lvl));

  a_r8_self_interferer: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_end && agg_idx == victim) |=> $stable(throttle_lvl));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((LW+1)'(lvl[i]) == (LW+1)'($past(lvl[i])) ||
                (LW+1)'(lvl[i]) == (LW+1)'($past(lvl[i])) + 1'b1 ||
                (LW+1)'(lvl[i]) + 1'b1 == (LW+1)'($past(lvl[i]))));
    a_r10_period_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(issue_period[i*PRW +: PRW]));
    a_r10_mshr_floor: assert property (@(posedge clk) disable iff (!rst_n)
      mshr_limit[i*MW +: MW] != '0);
  end
endmodule

// File: tb/test_throttle_ctrl.sv
`timescale 1ns/1ps
module test_throttle_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interval_end = 1'b0;
  logic mode = 1'b0;
  logic [15:0] unfair_target = '0;
  logic [63:0] core_target = '0;
  logic [63:0] slowdown = '0;
  logic [31:0] weight = '0;
  logic [255:0] interference = '0;
  logic [11:0] throttle_lvl;
  logic [31:0] issue_period;
  logic [19:0] mshr_limit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  throttle_ctrl i_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end), .mode(mode),
    .unfair_target(unfair_target), .core_target(core_target), .slowdown(slowdown),
    .weight(weight), .interference(interference), .throttle_lvl(throttle_lvl),
    .issue_period(issue_period), .mshr_limit(mshr_limit));

  typedef struct packed {
    logic        md;
    logic        flat;
    logic [1:0]  agg;
    logic [15:0] tgt;
    logic [15:0] s0, s1, s2, s3;
    logic [7:0]  w3;
    logic [2:0]  e0, e1, e2, e3;
  } vec_t;

  // md flat agg tgt s0 s1 s2 s3 w3 | expected levels of cores 0..3
  localparam vec_t TBL [15] = '{
    '{0,0,3,384, 256, 512, 256,256,16, 0,0,0,1},  // R4 R5 R6 R7
    '{0,0,3,512, 256, 512, 256,256,16, 0,0,0,1},  // R4 ratio equals target
    '{0,0,2,384, 768, 768, 256,256,16, 0,0,1,1},  // R5 tie
    '{0,0,0,512, 256, 256, 256,256,64, 1,0,1,0},  // R3 weight
    '{0,0,2,384, 256, 256, 640,256,16, 1,0,1,0},  // R8 self
    '{0,1,0,384, 256, 256, 512,256,16, 2,0,0,0},  // R6 tie
    '{1,0,3,384, 256, 512, 448,256,16, 2,0,0,1},  // R9 R11
    '{1,0,3,384, 128, 256, 256,256,16, 2,0,0,1},  // R11 hold in mode 1
    '{0,0,0,384, 256,1024, 256,256,16, 3,0,0,1},  // R7 saturation run
    '{0,0,0,384, 256,1024, 256,256,16, 4,0,0,1},
    '{0,0,0,384, 256,1024, 256,256,16, 5,0,0,1},
    '{0,0,0,384, 256,1024, 256,256,16, 6,0,0,1},
    '{0,0,0,384, 256,1024, 256,256,16, 7,0,0,1},
    '{0,0,0,384, 256,1024, 256,256,16, 7,0,0,1},  // R7 top saturation
    '{0,0,1,384,1024, 256, 256,256,16, 6,1,0,1}
  };

  task automatic drive(input vec_t v, input logic pulse);
    mode = v.md;
    unfair_target = v.tgt;
    for (int c = 0; c < N; c++) core_target[c*16 +: 16] = v.tgt;
    slowdown = {v.s3, v.s2, v.s1, v.s0};
    weight = {v.w3, 8'd16, 8'd16, 8'd16};
    for (int r = 0; r < N; r++)
      for (int a = 0; a < N; a++)
        interference[(r*N + a)*16 +: 16] = v.flat ? 16'd10 :
          (a == int'(v.agg)) ? 16'd50 : 16'(10 + r*a);
    interval_end = pulse;
  endtask

  task automatic check(input string tag, input logic [2:0] e0, e1, e2, e3);
    logic [11:0] el;
    logic [31:0] ep;
    logic [19:0] em;
    logic [2:0]  e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    for (int c = 0; c < N; c++) begin
      el[c*3 +: 3] = e[c];
      ep[c*8 +: 8] = 8'd1 << e[c];
      em[c*5 +: 5] = ((16 >> e[c]) == 0) ? 5'd1 : 5'(16 >> e[c]);
    end
    checks++;
    if (throttle_lvl !== el || issue_period !== ep || mshr_limit !== em) begin
      errors++;
      $display("FAIL %s: lvl=%h per=%h mshr=%h expected lvl=%h per=%h mshr=%h",
               tag, throttle_lvl, issue_period, mshr_limit, el, ep, em);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 0, 0, 0, 0);

    for (int k = 0; k < 15; k++) begin
      drive(TBL[k], 1'b1);
      @(negedge clk);
      interval_end = 1'b0;
      check($sformatf("vector %0d (R3-R11 table)", k),
            TBL[k].e0, TBL[k].e1, TBL[k].e2, TBL[k].e3);
    end

    // R2: acting inputs without the interval pulse must not move levels
    drive(TBL[8], 1'b0);
    repeat (3) @(negedge clk);
    check("R2 hold without interval_end", 6, 1, 0, 1);
    drive(TBL[8], 1'b1);
    @(negedge clk);
    interval_end = 1'b0;
    check("R2 update on interval_end", 7, 0, 0, 1);

    // R11: same stimulus as the mode 1 hold row acts under mode 0
    drive(TBL[7], 1'b1);
    mode = 1'b0;
    @(negedge clk);
    interval_end = 1'b0;
    check("R11 ratio mode acts", 7, 0, 0, 2);

    // R1: reset during operation clears every core
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule